// File: doc/BRIEF.md
# Burst Bus Interface Controller

This block sequences the external bus of an embedded 32-bit processor whose address and data share one set of 32 lines. A core-side request port hands over one aligned access: start address, direction, data-or-code flag, lane mask, burst length and the programmed port width. The block then walks the bus through an address cycle, one data cycle per transfer plus any wait states, and one or more recovery cycles. It returns to idle afterwards or yields the bus to an external master through a hold handshake.

Port widths of 8, 16 and 32 bits are supported. On narrow ports the low address bits leave on the byte-enable pins, so the external decoder sees a byte or halfword address. The ready input paces the data cycles and also stretches recovery, so slow devices get extra turnaround time. A hold request is only granted from idle or at the end of recovery, never straight out of a data cycle. Hold is also granted while the block sits in reset. Accesses are assumed aligned, and none is ever split.

Top module: `bus_burst_ctrl`

## Requirements
- R1: `req_ready_o` is high only in idle with `hold_i` low, and a request is taken on a rising edge where `req_valid_i` and `req_ready_o` are both high.
- R2: The cycle after a request is taken is the address cycle. In it `ads_no` is 0, `ale_o` is 1, `ad_oe_o` is 1, `ad_o[31:2]` carries address bits 31:2 and `ad_o[1:0]` carries the transfer count minus one.
- R3: `ads_no` is low in exactly one cycle per access, and high in every data, recovery, hold and idle cycle.
- R4: For transfer k, `a32_o` equals bits 3:2 of (start address + k × port bytes) taken modulo 16. Port bytes are 1, 2 or 4 for `port_width_i` = 00, 01 or 10.
- R5: Through the address and data cycles `be_no` is encoded per port width. For 32-bit (10) it is the inverted lane mask, held constant over the burst. For 16-bit (01) it is {~mask[1], 1, A1, ~mask[0]}. For 8-bit (00) it is {1, 1, A1, A0}, where A1/A0 are bits of the transfer address. `be_no` is 4'hF in recovery, idle and hold.
- R6: `blast_no` is 0 during every data cycle of the final transfer, including its wait cycles, and 1 otherwise.
- R7: In a data cycle, `ready_ni` = 0 completes the transfer at the next edge and `ready_ni` = 1 inserts a wait. A completing read gives `rd_valid_o` = 1 with `rd_data_o` = `ad_i`. A completing write gives `wr_beat_o` = 1. In write data cycles `ad_o` = `wr_data_i`.
- R8: After the final transfer exactly one recovery cycle follows if `ready_ni` is high. Each recovery cycle that samples `ready_ni` = 0 adds one more.
- R9: A hold request from idle gives `holda_o` = 1 one cycle later. A request raised during an access is granted only after the last recovery cycle. Dropping `hold_i` returns the block to idle one cycle later.
- R10: While `rst_ni` is low, `holda_o` follows `hold_i`.
- R11: Whenever `holda_o` is 1, `ctl_oe_o` and `ad_oe_o` are 0.
- R12: Over an access `wr_no` and `dtr_no` are 1 for write and 0 for read, `width_o` equals the captured `port_width_i`, `dc_no` is 1 for data and 0 for code, and `den_no` is 0 exactly in data cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this edge |
| req_addr_i | input | 32 | Start address, aligned |
| req_write_i | input | 1 | 1 = write |
| req_code_i | input | 1 | 1 = code fetch |
| req_be_i | input | 4 | Lane mask, active high |
| req_len_i | input | 2 | Transfers minus one |
| port_width_i | input | 2 | 00 = 8, 01 = 16, 10 = 32 bit |
| wr_data_i | input | 32 | Write data of the current transfer |
| wr_beat_o | output | 1 | Write transfer completes this edge |
| rd_data_o | output | 32 | Read data |
| rd_valid_o | output | 1 | Read transfer completes this edge |
| ad_o | output | 32 | Multiplexed address/data out |
| ad_oe_o | output | 1 | Drive enable of ad_o |
| ad_i | input | 32 | Multiplexed data in |
| a32_o | output | 2 | Address bits 3:2 of current transfer |
| ale_o | output | 1 | Address latch enable |
| ads_no | output | 1 | Address strobe, active low |
| be_no | output | 4 | Byte enables / narrow-port address |
| wr_no | output | 1 | 1 = write, 0 = read |
| dtr_no | output | 1 | 1 = transmit, 0 = receive |
| den_no | output | 1 | Data enable, active low |
| blast_no | output | 1 | Last transfer, active low |
| width_o | output | 2 | Port width of access |
| dc_no | output | 1 | 1 = data, 0 = code |
| ctl_oe_o | output | 1 | Drive enable of control outputs |
| ready_ni | input | 1 | Ready, active low |
| hold_i | input | 1 | Hold request |
| holda_o | output | 1 | Hold acknowledge |

## Verification
The address-cycle outputs are due on the first falling edge after the edge that took the request. Each data cycle's outputs are due on the falling edge after the previous transfer completed or waited. The bench drives `ready_ni` and read data at a falling edge and samples the completion strobes 1 ns later, before the rising edge that consumes them. Recovery and hold are checked one falling edge per state step, so every extra recovery cycle and the hold grant are each looked at in the exact cycle the requirements place them.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_RECOV,
    ST_HOLD
  } bus_state_e;

  localparam logic [1:0] PW_8  = 2'b00;
  localparam logic [1:0] PW_16 = 2'b01;

  // log2 of bytes moved per transfer
  function automatic logic [1:0] beat_shift(logic [1:0] pw);
    case (pw)
      PW_8:    return 2'd0;
      PW_16:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/bbc_seq.sv
module bbc_seq
  import bbc_pkg::*;
#(
  parameter int LEN_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             hold_i,
  input  logic             ready_ni,
  input  logic [LEN_W-1:0] len_i,
  output bus_state_e       state_o,
  output logic [LEN_W-1:0] beat_o,
  output logic             last_o
);
  bus_state_e       state_q, state_d;
  logic [LEN_W-1:0] beat_q;

  assign last_o  = (beat_q == len_i);
  assign state_o = state_q;
  assign beat_o  = beat_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (hold_i) state_d = ST_HOLD;
                else if (start_i) state_d = ST_ADDR;
      ST_ADDR:  state_d = ST_DATA;
      ST_DATA:  if (!ready_ni && last_o) state_d = ST_RECOV;
      // low ready in recovery stretches it; hold only granted on exit
      ST_RECOV: if (ready_ni) state_d = hold_i ? ST_HOLD : ST_IDLE;
      ST_HOLD:  if (!hold_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_ADDR) beat_q <= '0;
      else if (state_q == ST_DATA && !ready_ni && !last_o) beat_q <= beat_q + 1'b1;
    end
  end
endmodule

// File: rtl/bbc_lane.sv
module bbc_lane
  import bbc_pkg::*;
#(
  parameter int LEN_W = 2
) (
  input  logic [3:0]       base_lo_i,
  input  logic [LEN_W-1:0] beat_i,
  input  logic [1:0]       pw_i,
  input  logic [3:0]       mask_i,
  input  logic             active_i,
  output logic [1:0]       a32_o,
  output logic [3:0]       be_no
);
  logic [3:0] ofs, lo;

  always_comb begin
    ofs   = 4'(beat_i) << beat_shift(pw_i);
    lo    = base_lo_i + ofs;
    a32_o = lo[3:2];
    if (!active_i)           be_no = 4'hF;
    else if (pw_i == PW_8)   be_no = {2'b11, lo[1], lo[0]};
    else if (pw_i == PW_16)  be_no = {~mask_i[1], 1'b1, lo[1], ~mask_i[0]};
    else                     be_no = ~mask_i;
  end
endmodule

// File: rtl/bus_burst_ctrl.sv
module bus_burst_ctrl
  import bbc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              req_code_i,
  input  logic [3:0]        req_be_i,
  input  logic [1:0]        req_len_i,
  input  logic [1:0]        port_width_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic              wr_beat_o,
  output logic [ADDR_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [ADDR_W-1:0] ad_i,
  output logic [1:0]        a32_o,
  output logic              ale_o,
  output logic              ads_no,
  output logic [3:0]        be_no,
  output logic              wr_no,
  output logic              dtr_no,
  output logic              den_no,
  output logic              blast_no,
  output logic [1:0]        width_o,
  output logic              dc_no,
  output logic              ctl_oe_o,
  input  logic              ready_ni,
  input  logic              hold_i,
  output logic              holda_o
);
  localparam int LEN_W = 2;

  bus_state_e        state;
  logic [LEN_W-1:0]  beat;
  logic              last;
  logic              take;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q, code_q;
  logic [3:0]        mask_q;
  logic [LEN_W-1:0]  len_q;
  logic [1:0]        pw_q;
  logic              in_addr, in_data;

  assign req_ready_o = (state == ST_IDLE) && !hold_i;
  assign take        = req_valid_i && req_ready_o;
  assign in_addr     = (state == ST_ADDR);
  assign in_data     = (state == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      code_q  <= 1'b0;
      mask_q  <= '0;
      len_q   <= '0;
      pw_q    <= 2'b10;
    end else if (take) begin
      addr_q  <= req_addr_i;
      write_q <= req_write_i;
      code_q  <= req_code_i;
      mask_q  <= req_be_i;
      len_q   <= req_len_i;
      pw_q    <= port_width_i;
    end
  end

  bbc_seq #(.LEN_W(LEN_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (take),
    .hold_i  (hold_i),
    .ready_ni(ready_ni),
    .len_i   (len_q),
    .state_o (state),
    .beat_o  (beat),
    .last_o  (last)
  );

  bbc_lane #(.LEN_W(LEN_W)) u_lane (
    .base_lo_i(addr_q[3:0]),
    .beat_i   (in_data ? beat : '0),
    .pw_i     (pw_q),
    .mask_i   (mask_q),
    .active_i (in_addr || in_data),
    .a32_o    (a32_o),
    .be_no    (be_no)
  );

  always_comb begin
    if (in_addr)                 ad_o = {addr_q[ADDR_W-1:2], len_q};
    else if (in_data && write_q) ad_o = wr_data_i;
    else                         ad_o = '0;
  end

  // hold is honoured even while reset is applied
  assign holda_o    = (state == ST_HOLD) || (!rst_ni && hold_i);
  assign ctl_oe_o   = !holda_o;
  assign ad_oe_o    = !holda_o && (in_addr || (in_data && write_q));
  assign ale_o      = in_addr;
  assign ads_no     = !in_addr;
  assign den_no     = !in_data;
  assign blast_no   = !(in_data && last);
  assign wr_no      = write_q;
  assign dtr_no     = write_q;
  assign dc_no      = !code_q;
  assign width_o    = pw_q;
  assign rd_data_o  = ad_i;
  assign rd_valid_o = in_data && !ready_ni && !write_q;
  assign wr_beat_o  = in_data && !ready_ni && write_q;
endmodule

// File: rtl/bbc_checker.sv
module bbc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       ads_no,
  input logic       den_no,
  input logic       blast_no,
  input logic [3:0] be_no,
  input logic [1:0] width_o,
  input logic       holda_o,
  input logic       ctl_oe_o,
  input logic       ad_oe_o
);
  AST_ADS_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ads_no |=> ads_no); // R3
  AST_ADS_AFTER_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ads_no) |-> $past(req_valid_i && req_ready_o)); // R2
  AST_HOLD_NOT_FROM_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(holda_o) |-> $past(den_no)); // R9
  AST_FLOAT_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    holda_o |-> (!ctl_oe_o && !ad_oe_o)); // R11
  AST_BLAST_IN_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blast_no |-> !den_no); // R6
  AST_BE_STABLE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!den_no && $past(!den_no) && width_o == 2'b10) |-> $stable(be_no)); // R5
  AST_EXCLUSIVE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({!ads_no, !den_no, holda_o})); // R12
endmodule

bind bus_burst_ctrl bbc_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .ads_no     (ads_no),
  .den_no     (den_no),
  .blast_no   (blast_no),
  .be_no      (be_no),
  .width_o    (width_o),
  .holda_o    (holda_o),
  .ctl_oe_o   (ctl_oe_o),
  .ad_oe_o    (ad_oe_o)
);

// File: tb/bus_burst_ctrl_test.sv
`timescale 1ns/1ps
module bus_burst_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic        req_code_i = 1'b0;
  logic [3:0]  req_be_i = '0;
  logic [1:0]  req_len_i = '0;
  logic [1:0]  port_width_i = 2'b10;
  logic [31:0] wr_data_i = '0;
  logic        wr_beat_o;
  logic [31:0] rd_data_o;
  logic        rd_valid_o;
  logic [31:0] ad_o;
  logic        ad_oe_o;
  logic [31:0] ad_i = '0;
  logic [1:0]  a32_o;
  logic        ale_o, ads_no, wr_no, dtr_no, den_no, blast_no, dc_no, ctl_oe_o, holda_o;
  logic [3:0]  be_no;
  logic [1:0]  width_o;
  logic        ready_ni = 1'b1;
  logic        hold_i = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_burst_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_write_i(req_write_i), .req_code_i(req_code_i),
    .req_be_i(req_be_i), .req_len_i(req_len_i), .port_width_i(port_width_i),
    .wr_data_i(wr_data_i), .wr_beat_o(wr_beat_o), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ad_i(ad_i),
    .a32_o(a32_o), .ale_o(ale_o), .ads_no(ads_no), .be_no(be_no), .wr_no(wr_no),
    .dtr_no(dtr_no), .den_no(den_no), .blast_no(blast_no), .width_o(width_o),
    .dc_no(dc_no), .ctl_oe_o(ctl_oe_o), .ready_ni(ready_ni), .hold_i(hold_i),
    .holda_o(holda_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] lo_addr(logic [31:0] a, int k, logic [1:0] pw);
    int bytes = (pw == 2'b00) ? 1 : (pw == 2'b01) ? 2 : 4;
    return 4'((a[3:0] + k * bytes) % 16);
  endfunction

  function automatic logic [3:0] exp_be(logic [1:0] pw, logic [3:0] m, logic [3:0] lo);
    if (pw == 2'b00) return {2'b11, lo[1], lo[0]};
    if (pw == 2'b01) return {~m[1], 1'b1, lo[1], ~m[0]};
    return ~m;
  endfunction

  task automatic access(input logic [31:0] a, input bit wr, input bit code,
                        input logic [3:0] m, input logic [1:0] len,
                        input logic [1:0] pw, input int extra, input bit hold_mid);
    logic [3:0] lo;
    logic [31:0] d;
    int waits;
    if (pw == 2'b01) a[0] = 1'b0;
    if (pw == 2'b10) a[1:0] = 2'b00;
    @(negedge clk);
    chk("R1 ready in idle", 32'(req_ready_o), 32'd1);
    req_valid_i = 1'b1; req_addr_i = a; req_write_i = wr; req_code_i = code;
    req_be_i = m; req_len_i = len; port_width_i = pw; ready_ni = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R2 ads", 32'(ads_no), 32'd0);
    chk("R2 ale", 32'(ale_o), 32'd1);
    chk("R2 ad", ad_o, {a[31:2], len});
    chk("R2 ad_oe", 32'(ad_oe_o), 32'd1);
    chk("R1 busy", 32'(req_ready_o), 32'd0);
    chk("R12 wr", 32'({wr_no, dtr_no}), 32'({wr, wr}));
    chk("R12 width", 32'(width_o), 32'(pw));
    chk("R12 dc", 32'(dc_no), 32'(!code));
    chk("R4 a32 addr", 32'(a32_o), 32'(a[3:2]));
    chk("R5 be addr", 32'(be_no), 32'(exp_be(pw, m, lo_addr(a, 0, pw))));
    if (hold_mid) hold_i = 1'b1;
    @(negedge clk);
    for (int b = 0; b <= int'(len); b++) begin
      waits = $urandom % 3;
      lo = lo_addr(a, b, pw);
      for (int w = 0; w <= waits; w++) begin
        chk("R12 den", 32'(den_no), 32'd0);
        chk("R3 ads high", 32'(ads_no), 32'd1);
        chk("R4 a32", 32'(a32_o), 32'(lo[3:2]));
        chk("R5 be", 32'(be_no), 32'(exp_be(pw, m, lo)));
        chk("R6 blast", 32'(blast_no), 32'(b != int'(len)));
        d = $urandom;
        wr_data_i = d; ad_i = ~d;
        ready_ni = (w != waits);
        #1;
        if (w == waits) begin
          chk("R7 rd_valid", 32'(rd_valid_o), 32'(!wr));
          chk("R7 wr_beat", 32'(wr_beat_o), 32'(wr));
          if (!wr) chk("R7 rd_data", rd_data_o, ~d);
        end else begin
          chk("R7 wait", 32'({rd_valid_o, wr_beat_o}), 32'd0);
        end
        if (wr) chk("R7 wr data", ad_o, d);
        @(negedge clk);
      end
    end
    for (int r = 0; r <= extra; r++) begin
      chk("R8 recovery", 32'({req_ready_o, den_no, holda_o}), 32'b010);
      chk("R5 be off", 32'(be_no), 32'hF);
      chk("R3 ads off", 32'(ads_no), 32'd1);
      ready_ni = (r == extra);
      @(negedge clk);
    end
    if (hold_mid) begin
      chk("R9 hold after recov", 32'(holda_o), 32'd1);
      chk("R11 float", 32'({ctl_oe_o, ad_oe_o}), 32'd0);
      chk("R9 no req in hold", 32'(req_ready_o), 32'd0);
      hold_i = 1'b0;
      @(negedge clk);
      chk("R9 release", 32'(holda_o), 32'd0);
    end
    chk("R8 back to idle", 32'(req_ready_o), 32'd1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    hold_i = 1'b1;
    #10;
    chk("R10 hold in reset", 32'(holda_o), 32'd1);
    chk("R11 float in reset", 32'(ctl_oe_o), 32'd0);
    hold_i = 1'b0;
    #1;
    chk("R10 release in reset", 32'(holda_o), 32'd0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R3 reset ads", 32'(ads_no), 32'd1);
    chk("R5 reset be", 32'(be_no), 32'hF);
    chk("R6 reset blast", 32'(blast_no), 32'd1);
    chk("R12 reset den", 32'(den_no), 32'd1);
    chk("R1 reset ready", 32'(req_ready_o), 32'd1);
    // hold from idle
    hold_i = 1'b1; req_valid_i = 1'b1;
    #1; chk("R1 blocked by hold", 32'(req_ready_o), 32'd0);
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R9 idle grant", 32'(holda_o), 32'd1);
    chk("R3 no access taken", 32'(ads_no), 32'd1);
    hold_i = 1'b0;
    @(negedge clk);
    chk("R9 idle release", 32'(holda_o), 32'd0);
    // directed corners
    access(32'h1000_000C, 1'b0, 1'b1, 4'hF, 2'd3, 2'b10, 0, 1'b0); // wrap A[3:2]
    access(32'h2000_0003, 1'b1, 1'b0, 4'h1, 2'd3, 2'b00, 2, 1'b0); // 8-bit wrap
    access(32'h3000_0006, 1'b0, 1'b0, 4'h2, 2'd1, 2'b01, 0, 1'b1); // 16-bit, hold
    access(32'h4000_0000, 1'b1, 1'b1, 4'h6, 2'd0, 2'b10, 1, 1'b1);
    for (int i = 0; i < 60; i++)
      access($urandom, 1'($urandom), 1'($urandom), 4'($urandom), 2'($urandom),
             2'($urandom % 3), $urandom % 3, 1'($urandom % 4 == 0));
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule